// File: doc/BRIEF.md
# Locked Configuration Register Port

This block gives a host byte-wide access to a bank of configuration registers through only two addresses: an index location (address 0) and a data location (address 1). The host writes a register number to the index location, then reads or writes that register through the data location. The port starts out closed. It opens only after a fixed two-byte key has been written to the index location, and a separate one-byte key closes it again. Stray bus traffic therefore cannot alter the configuration.

The lower part of the register space is shared. It holds a logical-device select register, a 16-bit device identifier, a revision byte and a 16-bit vendor identifier. From 0x30 upward, registers are banked per logical device. Register 0x30 holds each device's enable bit inside this block. Registers above 0x30 are passed to the logical devices over an exported bank bus, which carries the selected device, the register number, a one-cycle write strobe and a read-data return. Logical device 7 is the watchdog timer, and its enable bit is also driven on a dedicated output.

The host bus is a plain synchronous strobe interface. A read strobe loads the registered read-data output on the next clock edge. One operation is issued per cycle.

Top module: `cfg_port`

## Requirements
- R1: After reset the port is closed, the index and device-select registers are 0, every device enable is 0, the watchdog enable output is 0, the bank write strobe is 0 and the read-data output is 0x00.
- R2: The port opens only when 0x87 is written to the index location (address 0) twice in a row. Any other index write between the two key bytes restarts the sequence. Data-location writes do not affect the key sequence.
- R3: While the port is open, writing 0xAA to the index location closes it and leaves the index register unchanged. Any other value written to the index location becomes the new index.
- R4: While the port is closed, reads of either location return 0xFF, data-location writes change no register, and index writes other than key bytes do not change the index.
- R5: While the port is open, registers 0x20/0x21 read as the device identifier (high byte at 0x20), 0x22 reads as the revision byte, and 0x23/0x24 read as the vendor identifier 0x1934 (high byte at 0x23). Writes to these registers are ignored.
- R6: Register 0x07 is read/write and holds the logical-device number that selects the bank answering registers 0x30 and above. It is driven on the bank bus device output.
- R7: Bit 0 of register 0x30 is the enable of the selected device. The register reads back as that bit with bits 7:1 zero. Each device has its own enable output bit, and the enable of device 7 also drives the watchdog enable output. If the selected number is not a device that exists, register 0x30 reads 0x00 and writes to it are ignored.
- R8: A data write to a register above 0x30 while the port is open produces exactly one bank write strobe in the following cycle, carrying the written byte, the register number and the selected device. A read of such a register returns the bank read-data input.
- R9: Read data is registered. It updates on the clock edge where the read strobe is sampled and holds its value otherwise. Unimplemented shared registers below 0x30 read 0x00.
- R10: While the port is open, a read of the index location returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 = index location, 1 = data location |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| bank_ld | output | 8 | Selected logical-device number |
| bank_idx | output | 8 | Current register number |
| bank_wr | output | 1 | One-cycle write strobe for registers above 0x30 |
| bank_wdata | output | 8 | Byte carried with bank_wr |
| bank_rdata | input | 8 | Read data returned by the selected device |
| dev_en | output | NUM_LD | Per-device enable bits |
| wdog_en | output | 1 | Enable bit of the watchdog device |

## Verification
The bench targets the key sequence at its edges. It sends a broken key (0x87, other value, 0x87), which a design that only counts key bytes would wrongly accept. It sends key bytes mixed with data-location writes, and it sends a close key that a faulty design would load as an index. While the port is closed, it attempts data writes to the select and enable registers and checks afterwards, through the open port, that they left no trace. It also selects device numbers beyond the last device, where a design with truncated decoding would alias onto a real device's enable. Finally, every bank write is checked for exactly one strobe carrying the right byte, register and device.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] REG_LDSEL   = 8'h07;
  localparam logic [7:0] REG_DEVID_H = 8'h20;
  localparam logic [7:0] REG_DEVID_L = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] REG_VEND_H  = 8'h23;
  localparam logic [7:0] REG_VEND_L  = 8'h24;
  localparam logic [7:0] REG_ENABLE  = 8'h30;

  typedef enum logic [1:0] {
    ST_SHUT = 2'd0,
    ST_HALF = 2'd1,
    ST_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic [7:0] idx_o
);
  key_state_e state_q;
  logic [7:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SHUT;
      idx_q   <= 8'h00;
    end else if (idx_wr) begin
      unique case (state_q)
        ST_SHUT: if (wdata == KEY_OPEN) state_q <= ST_HALF;
        ST_HALF: state_q <= (wdata == KEY_OPEN) ? ST_OPEN : ST_SHUT;
        ST_OPEN: begin
          if (wdata == KEY_CLOSE) state_q <= ST_SHUT;
          else                    idx_q   <= wdata;
        end
        default: state_q <= ST_SHUT;
      endcase
    end
  end

  assign open_o = (state_q == ST_OPEN);
  assign idx_o  = idx_q;

  p_idx_hold_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !open_o |=> $stable(idx_o));
  p_close_key_r3: assert property (@(posedge clk) disable iff (rst)
    (open_o && idx_wr && wdata == KEY_CLOSE) |=> (!open_o && $stable(idx_o)));
  p_open_after_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(idx_wr && wdata == KEY_OPEN));
endmodule

// File: rtl/cfg_shared_regs.sv
module cfg_shared_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0A51,
  parameter logic [15:0] VEND_ID = 16'h1934,
  parameter logic [7:0]  REV_ID  = 8'h11
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ld_sel,
  output logic [7:0] rd_val
);
  logic [7:0] ld_q;

  always_ff @(posedge clk) begin
    if (rst)                          ld_q <= 8'h00;
    else if (wr && idx == REG_LDSEL)  ld_q <= wdata;
  end

  always_comb begin
    unique case (idx)
      REG_LDSEL:   rd_val = ld_q;
      REG_DEVID_H: rd_val = DEV_ID[15:8];
      REG_DEVID_L: rd_val = DEV_ID[7:0];
      REG_REV:     rd_val = REV_ID;
      REG_VEND_H:  rd_val = VEND_ID[15:8];
      REG_VEND_L:  rd_val = VEND_ID[7:0];
      default:     rd_val = 8'h00;
    endcase
  end

  assign ld_sel = ld_q;
endmodule

// File: rtl/cfg_ld_enables.sv
module cfg_ld_enables #(
  parameter int NUM_LD = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [7:0]        sel,
  input  logic              bit_in,
  output logic              sel_valid,
  output logic              sel_bit,
  output logic [NUM_LD-1:0] en_o
);
  localparam int SEL_W = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;

  logic [NUM_LD-1:0] en_q;
  logic [SEL_W-1:0]  sel_n;

  assign sel_valid = ({24'd0, sel} < NUM_LD);
  assign sel_n     = sel[SEL_W-1:0];

  for (genvar g = 0; g < NUM_LD; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst)                                   en_q[g] <= 1'b0;
      else if (wr && sel_valid && sel_n == SEL_W'(g)) en_q[g] <= bit_in;
    end
  end

  assign sel_bit = sel_valid ? en_q[sel_n] : 1'b0;
  assign en_o    = en_q;

  p_no_write_bad_sel_r7: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |=> $stable(en_o));
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter int          NUM_LD  = 8,
  parameter int          WDOG_LD = 7,
  parameter logic [15:0] DEV_ID  = 16'h0A51,
  parameter logic [15:0] VEND_ID = 16'h1934,
  parameter logic [7:0]  REV_ID  = 8'h11
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        bank_ld,
  output logic [7:0]        bank_idx,
  output logic              bank_wr,
  output logic [7:0]        bank_wdata,
  input  logic [7:0]        bank_rdata,
  output logic [NUM_LD-1:0] dev_en,
  output logic              wdog_en
);
  logic       is_open;
  logic [7:0] idx;
  logic [7:0] ld_sel;
  logic [7:0] shared_rd;
  logic       sel_valid, sel_bit;
  logic       data_wr;
  logic       fwd_wr;
  logic [7:0] data_val;
  logic [7:0] rdata_q, bwdata_q;
  logic       bwr_q;

  assign data_wr = bus_wr && bus_addr && is_open;
  assign fwd_wr  = data_wr && (idx > REG_ENABLE);

  cfg_key_fsm u_key (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (bus_wr && !bus_addr),
    .wdata  (bus_wdata),
    .open_o (is_open),
    .idx_o  (idx)
  );

  cfg_shared_regs #(
    .DEV_ID  (DEV_ID),
    .VEND_ID (VEND_ID),
    .REV_ID  (REV_ID)
  ) u_shared (
    .clk    (clk),
    .rst    (rst),
    .wr     (data_wr),
    .idx    (idx),
    .wdata  (bus_wdata),
    .ld_sel (ld_sel),
    .rd_val (shared_rd)
  );

  cfg_ld_enables #(.NUM_LD(NUM_LD)) u_en (
    .clk       (clk),
    .rst       (rst),
    .wr        (data_wr && idx == REG_ENABLE),
    .sel       (ld_sel),
    .bit_in    (bus_wdata[0]),
    .sel_valid (sel_valid),
    .sel_bit   (sel_bit),
    .en_o      (dev_en)
  );

  always_comb begin
    if (idx < REG_ENABLE)       data_val = shared_rd;
    else if (idx == REG_ENABLE) data_val = {7'd0, sel_bit};
    else                        data_val = bank_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= 8'h00;
      bwr_q    <= 1'b0;
      bwdata_q <= 8'h00;
    end else begin
      bwr_q <= fwd_wr;
      if (fwd_wr) bwdata_q <= bus_wdata;
      if (bus_rd) begin
        if (!is_open)      rdata_q <= 8'hFF;
        else if (!bus_addr) rdata_q <= idx;
        else               rdata_q <= data_val;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bank_wr    = bwr_q;
  assign bank_wdata = bwdata_q;
  assign bank_ld    = ld_sel;
  assign bank_idx   = idx;
  assign wdog_en    = dev_en[WDOG_LD];

  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !is_open) |=> (bus_rdata == 8'hFF));
  p_en_hold_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !is_open |=> $stable(dev_en));
  p_ldsel_hold_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !is_open |=> $stable(bank_ld));
  p_strobe_source_r8: assert property (@(posedge clk) disable iff (rst)
    bank_wr |-> $past(bus_wr && bus_addr && is_open));
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/cfg_port_bench.sv
module cfg_port_bench;
  localparam int NLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, bank_ld, bank_idx, bank_wdata, bank_rdata;
  logic bank_wr, wdog_en;
  logic [NLD-1:0] dev_en;

  int checks = 0;
  int fails  = 0;

  // model state
  bit         m_open = 0, m_half = 0;
  logic [7:0] m_idx = 8'h00, m_ld = 8'h00;
  logic [NLD-1:0] m_en = '0;

  always #10 clk = ~clk;

  assign bank_rdata = bank_idx ^ {bank_ld[3:0], 4'hC};

  cfg_port u_cfg_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_ld(bank_ld),
    .bank_idx(bank_idx), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata), .dev_en(dev_en), .wdog_en(wdog_en)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_data();
    if (m_idx < 8'h30) begin
      case (m_idx)
        8'h07: return m_ld;
        8'h20: return 8'h0A;
        8'h21: return 8'h51;
        8'h22: return 8'h11;
        8'h23: return 8'h19;
        8'h24: return 8'h34;
        default: return 8'h00;
      endcase
    end else if (m_idx == 8'h30) begin
      return (m_ld < NLD) ? {7'd0, m_en[m_ld[2:0]]} : 8'h00;
    end
    return m_idx ^ {m_ld[3:0], 4'hC};
  endfunction

  task automatic wr(logic a, logic [7:0] d);
    bit fwd;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    fwd = 0;
    if (!a) begin
      if (m_open) begin
        if (d == 8'hAA) m_open = 0; else m_idx = d;
      end else if (m_half) begin
        m_half = 0;
        if (d == 8'h87) m_open = 1;
      end else if (d == 8'h87) m_half = 1;
    end else if (m_open) begin
      if (m_idx == 8'h07) m_ld = d;
      else if (m_idx == 8'h30 && m_ld < NLD) m_en[m_ld[2:0]] = d[0];
      else if (m_idx > 8'h30) fwd = 1;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 strobe", {31'd0, bank_wr}, {31'd0, fwd});
    if (fwd) begin
      check("R8 wdata", {24'd0, bank_wdata}, {24'd0, d});
      check("R8 idx",   {24'd0, bank_idx},   {24'd0, m_idx});
      check("R8 ld",    {24'd0, bank_ld},    {24'd0, m_ld});
    end
    check("R7 dev_en", {24'd0, dev_en}, {24'd0, m_en});
    check("R7 wdog_en", {31'd0, wdog_en}, {31'd0, m_en[7]});
  endtask

  task automatic rd(logic a, string req);
    logic [7:0] e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    if (!m_open) e = 8'hFF;
    else if (!a) e = m_idx;
    else e = exp_data();
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, {24'd0, bus_rdata}, {24'd0, e});
  endtask

  task automatic unlock();
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", {24'd0, bus_rdata}, 32'h0);
    check("R1 dev_en", {24'd0, dev_en}, 32'h0);
    check("R1 wdog_en", {31'd0, wdog_en}, 32'h0);
    check("R1 bank_wr", {31'd0, bank_wr}, 32'h0);
    check("R1 idx", {24'd0, bank_idx}, 32'h0);
    check("R1 ld", {24'd0, bank_ld}, 32'h0);
    // R4 closed port
    rd(1'b0, "R4 locked index read");
    rd(1'b1, "R4 locked data read");
    wr(1'b0, 8'h07);
    check("R4 idx unchanged", {24'd0, bank_idx}, 32'h0);
    // R2 broken key, data write in between
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    rd(1'b0, "R2 broken key stays closed");
    wr(1'b1, 8'h33); wr(1'b0, 8'h87);
    rd(1'b0, "R2 opened despite data write between keys");
    // R10 / R5 / R9
    wr(1'b0, 8'h20); rd(1'b0, "R10 index readback");
    rd(1'b1, "R5 devid hi");
    wr(1'b0, 8'h21); rd(1'b1, "R5 devid lo");
    wr(1'b0, 8'h22); rd(1'b1, "R5 rev");
    wr(1'b0, 8'h23); wr(1'b1, 8'hFF); rd(1'b1, "R5 vendor hi after write");
    wr(1'b0, 8'h24); rd(1'b1, "R5 vendor lo");
    wr(1'b0, 8'h10); rd(1'b1, "R9 unimplemented reads 0");
    held = bus_rdata;
    repeat (3) @(negedge clk);
    check("R9 rdata holds", {24'd0, bus_rdata}, {24'd0, held});
    // R6 / R7 watchdog enable
    wr(1'b0, 8'h07); wr(1'b1, 8'h07); rd(1'b1, "R6 ldsel readback");
    wr(1'b0, 8'h30); wr(1'b1, 8'hFF); rd(1'b1, "R7 enable reads bit0 only");
    check("R7 watchdog enable out", {31'd0, wdog_en}, 32'h1);
    // R7 out-of-range device
    wr(1'b0, 8'h07); wr(1'b1, 8'h0F);
    wr(1'b0, 8'h30); wr(1'b1, 8'h01); rd(1'b1, "R7 bad device reads 0");
    // R8 forwarding
    wr(1'b0, 8'h31); wr(1'b1, 8'hC3); rd(1'b1, "R8 bank read");
    // R3 close then closed writes ignored
    wr(1'b0, 8'hAA);
    check("R3 idx kept on close", {24'd0, bank_idx}, 32'h31);
    rd(1'b1, "R3 closed after key");
    wr(1'b1, 8'h00);
    unlock();
    rd(1'b0, "R4 idx unchanged across closed period");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] d;
      int k = $urandom_range(0, 7);
      case (k)
        0: d = 8'h07; 1: d = 8'h20; 2: d = 8'h24; 3: d = 8'h30;
        4: d = 8'h31; 5: d = 8'h87; 6: d = 8'hAA;
        default: d = 8'($urandom_range(0, 255));
      endcase
      if (r < 30) wr(1'b0, d);
      else if (r < 40) wr(1'b0, 8'h87);
      else if (r < 60) wr(1'b1, (m_idx == 8'h07) ? 8'($urandom_range(0, 9)) : 8'($urandom_range(0, 255)));
      else if (r < 80) rd(1'b1, "R5 R6 R7 R8 random data read");
      else rd(1'b0, "R2 R3 R10 random index read");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule